// File: doc/BRIEF.md
# Coalescing Block Write Buffer

This block sits between a write-through first-level data cache that does not allocate on write misses and the second-level cache. Every processor store enters it, whether the store hit the first-level cache or not. The buffer keeps a small number of slots, each covering one aligned 32-byte block as four 64-bit words with a per-word presence mask. A store to a block that a slot already holds is folded into that slot. This lets a run of stores to neighbouring words leave as a single block write rather than as several word writes.

A store to a block that no open slot holds takes a free slot. When every slot is taken and the store matches none of the open slots, the block raises a stall until the oldest slot has been written out. Slots drain in the order they were opened, through a valid/ready port. The port carries the block address, the block data, the word mask and a flag that tells the second level whether the write covers the whole block or only part of it, since the two kinds of write cost different amounts there.

A slot is offered for draining in three cases: every slot is taken, the oldest slot has become complete, or a flush has been requested. Once a slot is offered it is frozen. A flush pulse keeps the buffer draining until it is empty.

Top module: `blk_write_coalescer`

## Requirements
- R1: After reset the buffer is empty: `dr_valid` is low and a store to any block is accepted without `st_stall`.
- R2: A store to a block held by no open slot opens a new slot. When that slot drains, `dr_addr` equals `st_addr[31:5]`. The mask bit for word `st_addr[4:3]` is set, that word appears in lane `dr_data[64*w +: 64]`, and lanes that were never written read as zero.
- R3: A store to a block held by an open (not frozen) slot sets that word's mask bit in the same slot and uses up no further slot. A later store to the same word replaces the earlier data.
- R4: When all four slots are taken and a store matches no open slot, `st_stall` is high in the same cycle and the store is not taken. The stall clears in the cycle after a drain handshake.
- R5: A store that merges into an open slot never stalls, even when all slots are taken.
- R6: Slots drain oldest first. `dr_valid` rises only when the oldest slot exists and one of three things holds: all slots are taken, the oldest slot has all four words, or a flush is pending. Once `dr_valid` is raised, it and `dr_addr`, `dr_data` and `dr_mask` stay unchanged until `dr_ready` completes the handshake.
- R7: `dr_full` is high for a drained slot exactly when all four of its words are present (mask 4'b1111). Otherwise it marks a partial write.
- R8: While a slot is offered on the drain port it is frozen. A store to its block opens a new slot, which drains separately and later.
- R9: A one-cycle `flush` pulse makes the buffer drain every slot, even partial ones, until it is empty. After that `dr_valid` stays low.
- R10: Address bits `st_addr[2:0]` have no effect on where a store lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_addr | input | 32 | Store byte address |
| st_data | input | 64 | Store word data |
| st_stall | output | 1 | Store cannot be taken this cycle |
| flush | input | 1 | Pulse: drain until empty |
| dr_valid | output | 1 | Drain request valid |
| dr_ready | input | 1 | Second level takes the drain request |
| dr_addr | output | 27 | Block address of the drained slot |
| dr_data | output | 256 | Block data, word w in lane w |
| dr_mask | output | 4 | Present words of the drained slot |
| dr_full | output | 1 | Whole block present |

## Verification
The bench goes after four things. The first is merging: a same-word overwrite followed by a completing store, which a design that allocated on every store would expose as extra drains or a lost word. The second is the full-buffer boundary. There a non-matching store must stall while a merging store passes; a design that stalled on fullness alone would block the merge, and one that ignored fullness would overwrite a slot. The third is the frozen head. A store to the block being offered must go to a fresh slot behind the other slots, so a design that merged into it would change data under a pending request or lose the word. The fourth is flush and ordering. Partial slots must come out oldest first with the correct partial flag, and a design with the wrong pointer order or a stuck flush shows this as a wrong address sequence or a request that never ends.

// File: rtl/cwb_pkg.sv
package cwb_pkg;

   // Why the head slot is being offered on the drain port.
   typedef enum logic [1:0] {
      WHY_NONE     = 2'd0,
      WHY_CAPACITY = 2'd1,
      WHY_COMPLETE = 2'd2,
      WHY_FLUSH    = 2'd3
   } drain_why_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cwb_slot.sv
module cwb_slot #(
   parameter int BLK_W  = 27,
   parameter int WORDS  = 4,
   parameter int WORD_W = 64,
   localparam int WIX_W   = $clog2(WORDS),
   localparam int BLOCK_W = WORDS * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               open_i,
   input  logic               fold_i,
   input  logic               retire_i,
   input  logic [WIX_W-1:0]   word_i,
   input  logic [BLK_W-1:0]   blk_i,
   input  logic [WORD_W-1:0]  data_i,
   output logic               live_o,
   output logic [BLK_W-1:0]   blk_o,
   output logic [BLOCK_W-1:0] data_o,
   output logic [WORDS-1:0]   mask_o
);

   logic               live_q;
   logic [BLK_W-1:0]   blk_q;
   logic [BLOCK_W-1:0] data_q, data_d;
   logic [WORDS-1:0]   mask_q, mask_d;

   // Opening clears the block so unwritten lanes read as zero.
   always_comb begin
      data_d = open_i ? '0 : data_q;
      mask_d = open_i ? '0 : mask_q;
      data_d[word_i*WORD_W +: WORD_W] = data_i;
      mask_d[word_i] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         blk_q  <= '0;
         data_q <= '0;
         mask_q <= '0;
      end else begin
         if (open_i) begin
            live_q <= 1'b1;
            blk_q  <= blk_i;
            data_q <= data_d;
            mask_q <= mask_d;
         end else if (fold_i) begin
            data_q <= data_d;
            mask_q <= mask_d;
         end else if (retire_i) begin
            live_q <= 1'b0;
            mask_q <= '0;
         end
      end
   end

   assign live_o = live_q;
   assign blk_o  = blk_q;
   assign data_o = data_q;
   assign mask_o = mask_q;

endmodule

// File: rtl/cwb_lookup.sv
module cwb_lookup #(
   parameter int ENTRIES = 4,
   parameter int BLK_W   = 27
) (
   input  logic [ENTRIES-1:0]            live_i,
   input  logic [ENTRIES-1:0]            frozen_i,
   input  logic [ENTRIES-1:0][BLK_W-1:0] blk_i,
   input  logic [BLK_W-1:0]              key_i,
   output logic [ENTRIES-1:0]            hit_vec_o,
   output logic                          hit_o
);

   // One comparator per slot; a frozen slot never matches.
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec_o[g] = live_i[g] && !frozen_i[g] && (blk_i[g] == key_i);
   end

   assign hit_o = |hit_vec_o;

endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
   import cwb_pkg::*;
#(
   parameter int ENTRIES     = 4,
   parameter bit EARLY_DRAIN = 1'b1,
   localparam int PTR_W = $clog2(ENTRIES),
   localparam int CNT_W = $clog2(ENTRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             st_valid_i,
   input  logic             hit_i,
   input  logic             head_complete_i,
   input  logic             flush_i,
   input  logic             dr_ready_i,
   output logic [PTR_W-1:0] head_o,
   output logic [PTR_W-1:0] tail_o,
   output logic             open_o,
   output logic             retire_o,
   output logic             dr_valid_o,
   output logic             stall_o,
   output logic [CNT_W-1:0] count_o,
   output logic             flush_pend_o,
   output drain_why_e       why_o
);

   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] count_q, count_d;
   logic             flush_q;
   logic             at_cap, occupied, flush_any, complete_ok;

   assign at_cap    = (count_q == CNT_W'(ENTRIES));
   assign occupied  = (count_q != '0);
   assign flush_any = flush_i || flush_q;

   // Variant: whether a complete head may leave before capacity forces it.
   if (EARLY_DRAIN) begin : g_early
      assign complete_ok = head_complete_i;
   end else begin : g_late
      assign complete_ok = 1'b0;
   end

   always_comb begin
      why_o = WHY_NONE;
      if (occupied) begin
         if (flush_any)        why_o = WHY_FLUSH;
         else if (at_cap)      why_o = WHY_CAPACITY;
         else if (complete_ok) why_o = WHY_COMPLETE;
      end
   end

   assign dr_valid_o = (why_o != WHY_NONE);
   assign retire_o   = dr_valid_o && dr_ready_i;
   assign open_o     = st_valid_i && !hit_i && !at_cap;
   assign stall_o    = st_valid_i && !hit_i && at_cap;

   always_comb begin
      count_d = count_q;
      if (open_o && !retire_o)      count_d = count_q + 1'b1;
      else if (!open_o && retire_o) count_d = count_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
         flush_q <= 1'b0;
      end else begin
         if (retire_o) head_q <= head_q + 1'b1;
         if (open_o)   tail_q <= tail_q + 1'b1;
         count_q <= count_d;
         flush_q <= flush_any && (count_d != '0);
      end
   end

   assign head_o       = head_q;
   assign tail_o       = tail_q;
   assign count_o      = count_q;
   assign flush_pend_o = flush_q;

endmodule

// File: rtl/blk_write_coalescer.sv
module blk_write_coalescer
   import cwb_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int WORD_W      = 64,
   parameter int WORDS       = 4,
   parameter int ENTRIES     = 4,
   parameter bit EARLY_DRAIN = 1'b1,
   localparam int WORD_BYTES = WORD_W / 8,
   localparam int BYTE_OFF_W = $clog2(WORD_BYTES),
   localparam int WIX_W      = $clog2(WORDS),
   localparam int OFF_W      = BYTE_OFF_W + WIX_W,
   localparam int BLK_W      = ADDR_W - OFF_W,
   localparam int BLOCK_W    = WORDS * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               st_valid,
   input  logic [ADDR_W-1:0]  st_addr,
   input  logic [WORD_W-1:0]  st_data,
   output logic               st_stall,
   input  logic               flush,
   output logic               dr_valid,
   input  logic               dr_ready,
   output logic [BLK_W-1:0]   dr_addr,
   output logic [BLOCK_W-1:0] dr_data,
   output logic [WORDS-1:0]   dr_mask,
   output logic               dr_full
);

   localparam int PTR_W = $clog2(ENTRIES);
   localparam int CNT_W = $clog2(ENTRIES + 1);

   initial begin
      assert (is_pow2(ENTRIES) && ENTRIES >= 2)
         else $error("ENTRIES must be a power of two, at least 2");
      assert (is_pow2(WORDS) && WORDS >= 2)
         else $error("WORDS must be a power of two, at least 2");
      assert (is_pow2(WORD_BYTES) && (WORD_W % 8 == 0))
         else $error("WORD_W must be a power-of-two byte count");
      assert (BLK_W >= 1)
         else $error("ADDR_W too small for one block");
   end

   logic [BLK_W-1:0] st_blk;
   logic [WIX_W-1:0] st_word;
   wire              unused_byte_off = ^st_addr[BYTE_OFF_W-1:0];

   assign st_blk  = st_addr[ADDR_W-1:OFF_W];
   assign st_word = st_addr[OFF_W-1:BYTE_OFF_W];

   logic [ENTRIES-1:0]              slot_live, slot_hit, slot_frozen;
   logic [ENTRIES-1:0][BLK_W-1:0]   slot_blk;
   logic [ENTRIES-1:0][BLOCK_W-1:0] slot_data;
   logic [ENTRIES-1:0][WORDS-1:0]   slot_mask;
   logic                            any_hit, open_go, retire_go;
   logic [PTR_W-1:0]                head_ptr, tail_ptr;
   logic [CNT_W-1:0]                occ_cnt;
   logic                            flush_pend;
   logic                            head_complete;
   drain_why_e                      drain_why;

   cwb_lookup #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) u_lookup (
      .live_i    (slot_live),
      .frozen_i  (slot_frozen),
      .blk_i     (slot_blk),
      .key_i     (st_blk),
      .hit_vec_o (slot_hit),
      .hit_o     (any_hit)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic is_tail, is_head;
      assign is_tail        = (tail_ptr == PTR_W'(g));
      assign is_head        = (head_ptr == PTR_W'(g));
      assign slot_frozen[g] = dr_valid && is_head;

      cwb_slot #(.BLK_W(BLK_W), .WORDS(WORDS), .WORD_W(WORD_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .open_i   (open_go && is_tail),
         .fold_i   (st_valid && slot_hit[g]),
         .retire_i (retire_go && is_head),
         .word_i   (st_word),
         .blk_i    (st_blk),
         .data_i   (st_data),
         .live_o   (slot_live[g]),
         .blk_o    (slot_blk[g]),
         .data_o   (slot_data[g]),
         .mask_o   (slot_mask[g])
      );
   end

   assign head_complete = &slot_mask[head_ptr];

   cwb_ctrl #(.ENTRIES(ENTRIES), .EARLY_DRAIN(EARLY_DRAIN)) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .st_valid_i      (st_valid),
      .hit_i           (any_hit),
      .head_complete_i (head_complete),
      .flush_i         (flush),
      .dr_ready_i      (dr_ready),
      .head_o          (head_ptr),
      .tail_o          (tail_ptr),
      .open_o          (open_go),
      .retire_o        (retire_go),
      .dr_valid_o      (dr_valid),
      .stall_o         (st_stall),
      .count_o         (occ_cnt),
      .flush_pend_o    (flush_pend),
      .why_o           (drain_why)
   );

   assign dr_addr = slot_blk[head_ptr];
   assign dr_data = slot_data[head_ptr];
   assign dr_mask = slot_mask[head_ptr];
   assign dr_full = head_complete;

endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
   parameter int ENTRIES = 4,
   parameter int BLK_W   = 27,
   parameter int BLOCK_W = 256,
   parameter int WORDS   = 4,
   parameter int CNT_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               st_valid,
   input logic               st_stall,
   input logic               dr_valid,
   input logic               dr_ready,
   input logic [BLK_W-1:0]   dr_addr,
   input logic [BLOCK_W-1:0] dr_data,
   input logic [WORDS-1:0]   dr_mask,
   input logic [CNT_W-1:0]   count,
   input logic               flush_pend
);

   // R1: an empty buffer never requests a drain
   p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> !dr_valid);

   // R2: a drained slot always carries at least one word
   p_drain_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dr_valid |-> (dr_mask != '0));

   // R4: stall only answers a store, and only at capacity
   p_stall_needs_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st_stall |-> st_valid);

   p_stall_at_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      st_stall |-> (count == CNT_W'(ENTRIES)));

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(ENTRIES));

   // R6 / R8: an offered slot stays put until taken
   p_drain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_valid && !dr_ready) |=> (dr_valid && $stable(dr_addr)
                                   && $stable(dr_mask) && $stable(dr_data)));

   // R9: a pending flush with slots left keeps draining
   p_flush_progress_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_pend && count != '0) |-> dr_valid);

endmodule

bind blk_write_coalescer cwb_checker #(
   .ENTRIES (ENTRIES),
   .BLK_W   (BLK_W),
   .BLOCK_W (BLOCK_W),
   .WORDS   (WORDS),
   .CNT_W   ($clog2(ENTRIES + 1))
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .st_valid   (st_valid),
   .st_stall   (st_stall),
   .dr_valid   (dr_valid),
   .dr_ready   (dr_ready),
   .dr_addr    (dr_addr),
   .dr_data    (dr_data),
   .dr_mask    (dr_mask),
   .count      (occ_cnt),
   .flush_pend (flush_pend)
);

// File: tb/blk_write_coalescer_test.sv
`timescale 1ns/1ps
module blk_write_coalescer_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         st_valid = 1'b0;
   logic [31:0]  st_addr = '0;
   logic [63:0]  st_data = '0;
   logic         st_stall;
   logic         flush = 1'b0;
   logic         dr_valid;
   logic         dr_ready = 1'b0;
   logic [26:0]  dr_addr;
   logic [255:0] dr_data;
   logic [3:0]   dr_mask;
   logic         dr_full;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   blk_write_coalescer uut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
      .st_data(st_data), .st_stall(st_stall), .flush(flush),
      .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
      .dr_data(dr_data), .dr_mask(dr_mask), .dr_full(dr_full)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [26:0] blk, input int w, input int lo);
      return {blk, w[1:0], lo[2:0]};
   endfunction

   function automatic logic [255:0] put(input logic [255:0] v, input int w, input logic [63:0] d);
      logic [255:0] r = v;
      r[w*64 +: 64] = d;
      return r;
   endfunction

   task automatic store(input logic [31:0] a, input logic [63:0] d);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_data = d;
      #1;
      while (st_stall) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1 st_valid = 1'b0;
   endtask

   task automatic probe(input logic [31:0] a, output logic s);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_data = 64'hDEAD;
      #1 s = st_stall;
      st_valid = 1'b0;
   endtask

   task automatic take(input string req, input logic [26:0] ea, input logic [3:0] em,
                       input logic [255:0] ed, input logic ef);
      @(negedge clk);
      dr_ready = 1'b1;
      #1;
      while (!dr_valid) begin
         @(negedge clk);
         #1;
      end
      chk(dr_addr == ea, req, "drain address", 256'(dr_addr), 256'(ea));
      chk(dr_mask == em, req, "drain mask", 256'(dr_mask), 256'(em));
      chk(dr_data == ed, req, "drain data", dr_data, ed);
      chk(dr_full == ef, "R7", "full-block flag", 256'(dr_full), 256'(ef));
      @(posedge clk);
      #1 dr_ready = 1'b0;
   endtask

   task automatic pulse_flush();
      @(negedge clk);
      flush = 1'b1;
      @(posedge clk);
      #1 flush = 1'b0;
   endtask

   task automatic t_reset();
      logic s;
      @(negedge clk);
      chk(dr_valid == 1'b0, "R1", "drain idle after reset", 256'(dr_valid), 256'd0);
      probe(mk(27'h1, 0, 0), s);
      chk(s == 1'b0, "R1", "store accepted after reset", 256'(s), 256'd0);
   endtask

   task automatic t_single();
      logic [255:0] e = '0;
      store(mk(27'h0ABCDE, 2, 5), 64'h1111_2222_3333_4444);
      e = put(e, 2, 64'h1111_2222_3333_4444);
      repeat (3) @(negedge clk);
      chk(dr_valid == 1'b0, "R6", "partial slot not offered", 256'(dr_valid), 256'd0);
      pulse_flush();
      take("R2", 27'h0ABCDE, 4'b0100, e, 1'b0);
      repeat (3) @(negedge clk);
      chk(dr_valid == 1'b0, "R9", "empty after flush", 256'(dr_valid), 256'd0);
   endtask

   task automatic t_merge();
      logic [255:0] e = '0;
      logic [26:0]  a0;
      logic [3:0]   m0;
      logic [255:0] d0;
      store(mk(27'h0000F0, 0, 0), 64'hA0);
      store(mk(27'h0000F0, 1, 7), 64'hA1);
      store(mk(27'h0000F0, 1, 3), 64'hB1);
      store(mk(27'h0000F0, 2, 1), 64'hA2);
      e = put(e, 0, 64'hA0); e = put(e, 1, 64'hB1); e = put(e, 2, 64'hA2);
      @(negedge clk);
      chk(dr_valid == 1'b0, "R6", "three-word slot waits", 256'(dr_valid), 256'd0);
      store(mk(27'h0000F0, 3, 6), 64'hA3);
      e = put(e, 3, 64'hA3);
      @(negedge clk);
      chk(dr_valid == 1'b1, "R6", "complete head offered", 256'(dr_valid), 256'd1);
      a0 = dr_addr; m0 = dr_mask; d0 = dr_data;
      repeat (2) @(negedge clk);
      chk(dr_valid && dr_addr == a0 && dr_mask == m0 && dr_data == d0, "R6",
          "offer held without ready", 256'(dr_valid), 256'd1);
      take("R3", 27'h0000F0, 4'b1111, e, 1'b1);
      repeat (3) @(negedge clk);
      chk(dr_valid == 1'b0, "R3", "merges used one slot", 256'(dr_valid), 256'd0);
   endtask

   task automatic t_capacity();
      logic s;
      logic [255:0] ea = '0, eb = '0, ec = '0, ed = '0, ea2 = '0;
      store(mk(27'h100, 0, 0), 64'hC0); ea = put(ea, 0, 64'hC0);
      store(mk(27'h200, 0, 0), 64'hC1); eb = put(eb, 0, 64'hC1);
      store(mk(27'h300, 0, 0), 64'hC2); ec = put(ec, 0, 64'hC2);
      store(mk(27'h400, 0, 0), 64'hC3); ed = put(ed, 0, 64'hC3);
      @(negedge clk);
      chk(dr_valid == 1'b1, "R6", "offer at capacity", 256'(dr_valid), 256'd1);
      probe(mk(27'h500, 0, 0), s);
      chk(s == 1'b1, "R4", "new block stalls when full", 256'(s), 256'd1);
      probe(mk(27'h200, 1, 0), s);
      chk(s == 1'b0, "R5", "merging store not stalled", 256'(s), 256'd0);
      store(mk(27'h200, 1, 0), 64'hD1); eb = put(eb, 1, 64'hD1);
      probe(mk(27'h100, 1, 0), s);
      chk(s == 1'b1, "R8", "frozen head not a merge target", 256'(s), 256'd1);
      take("R6", 27'h100, 4'b0001, ea, 1'b0);
      probe(mk(27'h500, 0, 0), s);
      chk(s == 1'b0, "R4", "stall released after drain", 256'(s), 256'd0);
      chk(dr_valid == 1'b0, "R6", "partial head waits below capacity", 256'(dr_valid), 256'd0);
      store(mk(27'h100, 1, 2), 64'hE1); ea2 = put(ea2, 1, 64'hE1);
      pulse_flush();
      take("R6", 27'h200, 4'b0011, eb, 1'b0);
      take("R6", 27'h300, 4'b0001, ec, 1'b0);
      take("R6", 27'h400, 4'b0001, ed, 1'b0);
      take("R8", 27'h100, 4'b0010, ea2, 1'b0);
      repeat (3) @(negedge clk);
      chk(dr_valid == 1'b0, "R9", "flush empties buffer", 256'(dr_valid), 256'd0);
   endtask

   task automatic t_lowbits();
      logic [255:0] e = '0;
      store(mk(27'h777, 3, 7), 64'h55);
      store(mk(27'h777, 3, 0), 64'h66);
      e = put(e, 3, 64'h66);
      pulse_flush();
      take("R10", 27'h777, 4'b1000, e, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_single();
      t_merge();
      t_capacity();
      t_lowbits();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule